// File: doc/BRIEF.md
# Sleep wake-up event detector

This block recognises the two ways a sleeping bus node can be woken. One is a local wake: a falling edge on a digital wake pin, followed by the pin staying low for a minimum hold time. The other is a bus wake: the single-wire bus stays dominant for a minimum time and then returns to recessive. Both inputs are asynchronous. Each passes through its own synchroniser before any decision is made. The two minimum durations are parameters counted in clock cycles. Typical settings cover about 7 to 50 µs for the pin and about 30 to 150 µs for the bus.

The mode controller drives `arm` high while the node sleeps and during the filter window before sleep entry. While `arm` is low, both detectors sit in their idle state and no event comes out. A detected event appears as a single-cycle registered pulse, together with a registered source flag.

Top module: `wake_sense_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `wake_pulse_o` and `wake_local_o` are both 0.
- R2: A local wake fires when, while armed, the synchronised pin falls from high and then gives PIN_HOLD consecutive low samples. `wake_pulse_o` rises PIN_HOLD+2 clock cycles after the pin falls, with `wake_local_o` = 1. The pulse also fires if the pin goes high again right after the PIN_HOLD-th low sample.
- R3: If the pin returns high after fewer than PIN_HOLD low samples, the hold count clears and no event is produced.
- R4: If the pin is already low when `arm` rises, it gives no event until it has been seen high and falls again.
- R5: A bus wake fires when, while armed, the bus goes from recessive (`bus_rx_i` = 1) to dominant (`bus_rx_i` = 0), stays dominant for at least BUS_HOLD samples, and then returns to recessive. `wake_pulse_o` rises 3 cycles after the recessive level is applied, with `wake_local_o` = 0.
- R6: A dominant phase shorter than BUS_HOLD samples, followed by recessive, produces no event.
- R7: A bus held dominant with no return to recessive produces no event. The same holds for a dominant phase that was already present when `arm` rose.
- R8: While `arm` is low, neither source produces an event. Dropping `arm` in the middle of a hold window discards that window.
- R9: If a local and a bus wake are recognised in the same cycle, one pulse is produced with `wake_local_o` = 1.
- R10: Each event gives exactly one pulse of one cycle. `wake_local_o` is 0 whenever `wake_pulse_o` is 0.
- R11: A pin that stays low after a local wake gives no further events until it goes high and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Detection enable from the mode controller |
| wake_pin_i | input | 1 | Asynchronous local wake pin, idle high |
| bus_rx_i | input | 1 | Asynchronous digitised bus level, 1 recessive, 0 dominant |
| wake_pulse_o | output | 1 | One-cycle wake event pulse |
| wake_local_o | output | 1 | Event source: 1 local pin, 0 bus; valid with the pulse |

## Verification
Every input passes through SYNC_STAGES synchroniser flops, then one decision cycle, then the output register. A bus wake therefore shows on the pulse 3 cycles after the recessive level is driven. A local wake shows PIN_HOLD+2 cycles after the falling edge. The bench drives all inputs on the falling clock edge and samples the outputs just before driving, on the same falling edge. It logs the cycle index of every pulse and compares that index with these latencies. To test the local-wins rule, the bus rise is scheduled so that both events are due in the same cycle. The bench then checks that only one pulse appears, with the local source flag set.

// File: rtl/wake_sense_pkg.sv
package wake_sense_pkg;

  typedef enum logic [1:0] {
    PIN_IDLE,
    PIN_READY,
    PIN_HOLDING,
    PIN_SPENT
  } pin_state_t;

  typedef enum logic [1:0] {
    BUS_WAIT,
    BUS_QUIET,
    BUS_ACTIVE
  } bus_state_t;

  localparam logic SRC_LOCAL = 1'b1;
  localparam logic SRC_BUS   = 1'b0;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= {STAGES{RST_VAL[b]}};
      end else begin
        chain <= {chain[STAGES-2:0], d_i[b]};
      end
    end
    assign q_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/wake_pin_det.sv
module wake_pin_det
  import wake_sense_pkg::*;
#(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic pin_s,
  output logic hit_o
);

  localparam int CW = $clog2(HOLD + 1);

  pin_state_t    st;
  logic [CW-1:0] cnt;
  logic          low;

  assign low   = !pin_s;
  assign hit_o = arm && low &&
                 (((st == PIN_READY) && (HOLD == 1)) ||
                  ((st == PIN_HOLDING) && (cnt == CW'(HOLD - 1))));

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      st  <= PIN_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        PIN_IDLE: begin
          if (!low) st <= PIN_READY;
        end
        PIN_READY: begin
          if (low) begin
            if (hit_o) begin
              st <= PIN_SPENT;
            end else begin
              st  <= PIN_HOLDING;
              cnt <= CW'(1);
            end
          end
        end
        PIN_HOLDING: begin
          if (!low) begin
            st  <= PIN_READY;
            cnt <= '0;
          end else if (hit_o) begin
            st  <= PIN_SPENT;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          if (!low) st <= PIN_READY;
        end
      endcase
    end
  end

endmodule

// File: rtl/wake_bus_det.sv
module wake_bus_det
  import wake_sense_pkg::*;
#(
  parameter int HOLD = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic rec_s,
  output logic hit_o
);

  localparam int CW = $clog2(HOLD + 1);

  bus_state_t    st;
  logic [CW-1:0] cnt;

  assign hit_o = arm && rec_s && (st == BUS_ACTIVE) && (cnt == CW'(HOLD));

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      st  <= BUS_WAIT;
      cnt <= '0;
    end else begin
      case (st)
        BUS_WAIT: begin
          if (rec_s) st <= BUS_QUIET;
        end
        BUS_QUIET: begin
          if (!rec_s) begin
            st  <= BUS_ACTIVE;
            cnt <= CW'(1);
          end
        end
        BUS_ACTIVE: begin
          if (rec_s) begin
            st  <= BUS_QUIET;
            cnt <= '0;
          end else if (cnt != CW'(HOLD)) begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= BUS_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/wake_sense_top.sv
module wake_sense_top
  import wake_sense_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIN_HOLD    = 8,
  parameter int BUS_HOLD    = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic wake_pin_i,
  input  logic bus_rx_i,
  output logic wake_pulse_o,
  output logic wake_local_o
);

  localparam int NSIG = 2;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            pin_s;
  logic            bus_s;
  logic            pin_hit;
  logic            bus_hit;

  assign raw   = {bus_rx_i, wake_pin_i};
  assign pin_s = synced[0];
  assign bus_s = synced[1];

  wake_sync #(
    .WIDTH  (NSIG),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(raw),
    .q_o(synced)
  );

  wake_pin_det #(.HOLD(PIN_HOLD)) u_pin (
    .clk  (clk),
    .rst  (rst),
    .arm  (arm),
    .pin_s(pin_s),
    .hit_o(pin_hit)
  );

  wake_bus_det #(.HOLD(BUS_HOLD)) u_bus (
    .clk  (clk),
    .rst  (rst),
    .arm  (arm),
    .rec_s(bus_s),
    .hit_o(bus_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_pulse_o <= 1'b0;
      wake_local_o <= 1'b0;
    end else begin
      wake_pulse_o <= pin_hit || bus_hit;
      wake_local_o <= pin_hit ? SRC_LOCAL : SRC_BUS;
    end
  end

endmodule

// File: rtl/wake_sense_chk.sv
module wake_sense_chk (
  input logic clk,
  input logic rst,
  input logic arm,
  input logic pin_s,
  input logic bus_s,
  input logic wake_pulse_o,
  input logic wake_local_o
);

  // R2
  local_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_pulse_o && wake_local_o) |-> !$past(pin_s));

  // R5
  bus_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_pulse_o && !wake_local_o) |-> ($past(bus_s) && !$past(bus_s, 2)));

  // R8
  armed_only_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse_o |-> $past(arm));

  // R10
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse_o |=> !wake_pulse_o);

  // R10
  src_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wake_local_o |-> wake_pulse_o);

endmodule

bind wake_sense_top wake_sense_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .arm         (arm),
  .pin_s       (pin_s),
  .bus_s       (bus_s),
  .wake_pulse_o(wake_pulse_o),
  .wake_local_o(wake_local_o)
);

// File: tb/sim_wake_sense_top.sv
module sim_wake_sense_top;

  localparam int PH   = 8;
  localparam int BH   = 12;
  localparam int SPAN = 44;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic pin = 1'b1;
  logic bus = 1'b1;
  logic pulse;
  logic src;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  wake_sense_top #(.SYNC_STAGES(2), .PIN_HOLD(PH), .BUS_HOLD(BH)) u0 (
    .clk         (clk),
    .rst         (rst),
    .arm         (arm),
    .wake_pin_i  (pin),
    .bus_rx_i    (bus),
    .wake_pulse_o(pulse),
    .wake_local_o(src)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; arm = 1'b0; pin = 1'b1; bus = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Cycle-indexed schedule: -1 means never. Inputs are driven at negedge c,
  // outputs are sampled at the same negedge just before driving.
  task automatic run_case(input string req, input int lf, input int lr,
                          input int bf, input int br, input int a_on, input int a_off,
                          input int exp_c, input int exp_src);
    int first = -1;
    int n = 0;
    int fsrc = 0;
    int stray = 0;
    do_reset();
    for (int c = 0; c < SPAN; c++) begin
      @(negedge clk);
      if (pulse) begin
        n++;
        if (first < 0) begin
          first = c;
          fsrc  = int'(src);
        end
      end else if (src) begin
        stray++;
      end
      pin = !((lf >= 0) && (c >= lf) && !((lr >= 0) && (c >= lr)));
      bus = !((bf >= 0) && (c >= bf) && !((br >= 0) && (c >= br)));
      arm = (a_on >= 0) && (c >= a_on) && !((a_off >= 0) && (c >= a_off));
    end
    arm = 1'b0;
    check(req, "pulse count", n, (exp_c >= 0) ? 1 : 0);
    check("R10", "source without pulse", stray, 0);
    if (exp_c >= 0) begin
      check(req, "pulse cycle", first, exp_c);
      check(req, "source flag", fsrc, exp_src);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; arm = 1'b1; pin = 1'b0; bus = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "pulse in reset", int'(pulse), 0);
    check("R1", "source in reset", int'(src), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "pulse after reset", int'(pulse), 0);
    check("R1", "source after reset", int'(src), 0);
  endtask

  task automatic t_local_held();   run_case("R11", 2, -1, -1, -1, 0, -1, 2 + PH + 2, 1); endtask
  task automatic t_local_exact();  run_case("R2", 2, 2 + PH, -1, -1, 0, -1, 2 + PH + 2, 1); endtask
  task automatic t_local_short();  run_case("R3", 2, 2 + PH - 1, -1, -1, 0, -1, -1, 0); endtask
  task automatic t_local_prelow(); run_case("R4", 0, 25, -1, -1, 15, -1, -1, 0); endtask
  task automatic t_local_unarm();  run_case("R8", 2, -1, -1, -1, -1, -1, -1, 0); endtask
  task automatic t_local_drop();   run_case("R8", 2, -1, -1, -1, 0, 8, -1, 0); endtask
  task automatic t_bus_ok();       run_case("R5", -1, -1, 2, 2 + BH, 0, -1, 2 + BH + 3, 0); endtask
  task automatic t_bus_short();    run_case("R6", -1, -1, 2, 2 + BH - 1, 0, -1, -1, 0); endtask
  task automatic t_bus_stuck();    run_case("R7", -1, -1, 2, -1, 0, -1, -1, 0); endtask
  task automatic t_bus_predom();   run_case("R7", -1, -1, 0, 25, 10, -1, -1, 0); endtask
  task automatic t_bus_unarm();    run_case("R8", -1, -1, 2, 2 + BH, -1, -1, -1, 0); endtask
  task automatic t_both();         run_case("R9", 8, -1, 2, 15, 0, -1, 18, 1); endtask

  initial begin
    t_reset();
    t_local_held();
    t_local_exact();
    t_local_short();
    t_local_prelow();
    t_local_unarm();
    t_local_drop();
    t_bus_ok();
    t_bus_short();
    t_bus_stuck();
    t_bus_predom();
    t_bus_unarm();
    t_both();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule